// File: doc/BRIEF.md
# PLCP Frame Alignment Receiver

This block takes a bit-serial PLCP stream, qualified by a bit enable, and finds the row and octet boundaries in it. While searching, a sliding 16-bit window compares every bit position against the framing pair, 0xF6 then 0x28, sent MSB first. The first hit fixes octet alignment. The block then waits for a second framing pair and for an identifier octet that is the correct successor of the first. Only then does it declare the stream in frame.

Once aligned, the block checks every row's two framing octets and its identifier octet. It reports any mismatch as a one-cycle frame error pulse. It leaves frame when both framing octets are corrupt in the same row, or when two identifiers in a row are wrong.

While in frame, each row's path overhead octet is sent out bit-serially with its own enable and a frame-start pulse. A debounced yellow alarm is taken from one overhead bit per frame. An external request, typically from a loss-of-frame timer, forces a new search at any time.

Top module: `plcp_frame_rx`

## Requirements
- R1: A row is 57 octets: framing octets 0xF6 and 0x28, an identifier, a path overhead octet and 53 payload octets, all sent MSB first. Row r (0..11) of a 12-row frame carries identifier {k, ~k} with k = 11 - r, as upper and lower nibble. After a framing pair hit, the next row must also carry a correct framing pair and the successor identifier. `oof` falls on the clock edge that takes the last bit of that second identifier.
- R2: During acquisition, a second row whose identifier is not the successor of the first, or whose framing pair is wrong, keeps `oof` high and restarts the search.
- R3: In frame, a row with both framing octets wrong raises `oof` at the end of that row's identifier octet.
- R4: In frame, two consecutive rows with a wrong identifier raise `oof`. A single wrong identifier does not.
- R5: In frame, each row with any framing or identifier mismatch gives exactly one one-cycle `frame_err` pulse. No pulse is given while out of frame.
- R6: In frame, an error in only one of the two framing octets leaves `oof` low.
- R7: While in frame, each overhead octet bit appears on `poh_data` with `poh_en` high for one cycle, MSB first, one clock after its input bit. This starts with the overhead octet of the row in which frame is declared. Nothing is emitted out of frame.
- R8: `poh_fp` is high with the first overhead bit of the row carrying identifier k = 11, and at no other time.
- R9: The yellow bit is bit 3 (weight 0x08) of the overhead octet of row 8. `yellow` sets after 10 consecutive such bits equal to 1 and clears after 10 consecutive equal to 0.
- R10: `reframe_req` forces `oof` high on the next clock and stops overhead output.
- R11: After reset `oof` is 1 and `frame_err`, `yellow`, `poh_en` and `poh_fp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line data |
| reframe_req | input | 1 | Forces a new framing search |
| oof | output | 1 | Out-of-frame flag |
| frame_err | output | 1 | One-cycle pulse on a framing or identifier mismatch in frame |
| yellow | output | 1 | Debounced yellow alarm |
| poh_data | output | 1 | Serial path overhead bit |
| poh_en | output | 1 | Qualifies `poh_data` |
| poh_fp | output | 1 | Marks the first overhead bit of a frame |

## Verification
The assertions assume that `bit_en`, `bit_in` and `reframe_req` are synchronous to `clk`. They also assume that a request is a lone pulse, so that the only ways out of frame are a request or an identifier-octet boundary. The stimulus changes every input on the falling edge. It fills the payload and overhead octets with values that cannot form 0xF628 at any bit offset, so the search locks only on real framing pairs. Requests are issued only between rows.

// File: rtl/plcp_rx_pkg.sv
package plcp_rx_pkg;

  localparam int ID_W = 4;

  typedef enum logic [1:0] {ST_HUNT, ST_CHK1, ST_CHK2, ST_LOCK} align_st_e;

  // identifier octet for countdown value k: k in the upper nibble, its inverse below
  function automatic logic [7:0] id_code(input logic [ID_W-1:0] k);
    return {k, ~k};
  endfunction

  function automatic logic id_legal(input logic [7:0] c, input int rows);
    return (c[7:4] == ~c[3:0]) && (int'(c[7:4]) < rows);
  endfunction

  // row index <-> countdown value (the mapping is its own inverse)
  function automatic logic [ID_W-1:0] row_to_k(input logic [ID_W-1:0] v, input int rows);
    return ID_W'(rows - 1) - v;
  endfunction

endpackage

// File: rtl/plcp_align_fsm.sv
module plcp_align_fsm
  import plcp_rx_pkg::*;
#(
  parameter int          ROW_OCTETS = 57,
  parameter int          ROWS       = 12,
  parameter logic [15:0] FRAME_PAT  = 16'hF628,
  localparam int         OCT_W      = $clog2(ROW_OCTETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             reframe_req,
  output logic             in_frame,
  output logic             frame_err,
  output logic [OCT_W-1:0] octet_idx,
  output logic [2:0]       bit_idx,
  output logic [ID_W-1:0]  row_idx
);

  localparam logic [OCT_W-1:0] OCT_LAST = OCT_W'(ROW_OCTETS - 1);
  localparam logic [ID_W-1:0]  ROW_LAST = ID_W'(ROWS - 1);

  align_st_e   state;
  logic [14:0] sr;
  logic [15:0] win;
  logic [7:0]  oct_now, id_exp;
  logic        oct_end, pair_end, id_end, pat_hit;
  logic        a1_bad, a2_bad, id_bad;
  logic        pa1_bad, pa2_bad, prev_id_bad;

  assign win      = {sr, bit_in};
  assign oct_now  = win[7:0];
  assign oct_end  = bit_en && (bit_idx == 3'd7);
  assign pair_end = oct_end && (octet_idx == OCT_W'(1));
  assign id_end   = oct_end && (octet_idx == OCT_W'(2));
  assign pat_hit  = bit_en && (win == FRAME_PAT);
  assign a1_bad   = win[15:8] != FRAME_PAT[15:8];
  assign a2_bad   = oct_now != FRAME_PAT[7:0];
  assign id_exp   = id_code(row_to_k(row_idx, ROWS));
  assign id_bad   = oct_now != id_exp;
  assign in_frame = (state == ST_LOCK);

  // sliding window over the line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (bit_en) sr <= win[14:0];
  end

  // bit / octet / row position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      octet_idx <= '0;
      row_idx   <= '0;
    end else if (!reframe_req) begin
      if (state == ST_HUNT) begin
        if (pat_hit) begin
          bit_idx   <= '0;
          octet_idx <= OCT_W'(2);
        end
      end else if (bit_en) begin
        bit_idx <= bit_idx + 3'd1;
        if (oct_end) begin
          if (octet_idx == OCT_LAST) begin
            octet_idx <= '0;
            row_idx   <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
          end else begin
            octet_idx <= octet_idx + 1'b1;
          end
        end
        if (state == ST_CHK1 && id_end && id_legal(oct_now, ROWS))
          row_idx <= row_to_k(oct_now[7:4], ROWS);
      end
    end
  end

  // acquisition and maintenance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      pa1_bad     <= 1'b0;
      pa2_bad     <= 1'b0;
      prev_id_bad <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (reframe_req) begin
        state       <= ST_HUNT;
        prev_id_bad <= 1'b0;
      end else if (state == ST_HUNT) begin
        if (pat_hit) state <= ST_CHK1;
      end else begin
        if (pair_end) begin
          pa1_bad <= a1_bad;
          pa2_bad <= a2_bad;
        end
        if (id_end) begin
          case (state)
            ST_CHK1: state <= id_legal(oct_now, ROWS) ? ST_CHK2 : ST_HUNT;
            ST_CHK2: begin
              if (!pa1_bad && !pa2_bad && !id_bad) begin
                state       <= ST_LOCK;
                prev_id_bad <= 1'b0;
              end else begin
                state <= ST_HUNT;
              end
            end
            default: begin
              frame_err   <= pa1_bad || pa2_bad || id_bad;
              prev_id_bad <= id_bad;
              if ((pa1_bad && pa2_bad) || (id_bad && prev_id_bad)) state <= ST_HUNT;
            end
          endcase
        end
      end
    end
  end

  assert_lock_via_second_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(state) == ST_CHK2);
  assert_err_only_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_frame));
  assert_err_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  assert_reframe_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |=> !in_frame);
  assert_drop_at_id_octet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_frame) && !$past(reframe_req)) |-> $past(id_end));

endmodule

// File: rtl/plcp_poh_tap.sv
module plcp_poh_tap
  import plcp_rx_pkg::*;
#(
  parameter int OCT_W   = 6,
  parameter int POH_OCT = 3,
  parameter int YEL_ROW = 8,
  parameter int YEL_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             in_frame,
  input  logic [OCT_W-1:0] octet_idx,
  input  logic [2:0]       bit_idx,
  input  logic [ID_W-1:0]  row_idx,
  output logic             poh_data,
  output logic             poh_en,
  output logic             poh_fp,
  output logic             yel_valid,
  output logic             yel_bit
);

  logic       take;
  logic [6:0] acc;
  logic [7:0] full;

  assign take = in_frame && bit_en && (octet_idx == OCT_W'(POH_OCT));
  assign full = {acc, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poh_data  <= 1'b0;
      poh_en    <= 1'b0;
      poh_fp    <= 1'b0;
      acc       <= '0;
      yel_valid <= 1'b0;
      yel_bit   <= 1'b0;
    end else begin
      poh_en    <= take;
      poh_data  <= take && bit_in;
      poh_fp    <= take && (row_idx == '0) && (bit_idx == 3'd0);
      yel_valid <= take && (bit_idx == 3'd7) && (row_idx == ID_W'(YEL_ROW));
      yel_bit   <= full[YEL_BIT];
      if (take) acc <= full[6:0];
    end
  end

  assert_fp_with_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poh_fp |-> poh_en);
  assert_poh_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poh_en |-> $past(in_frame));

endmodule

// File: rtl/plcp_yellow_filter.sv
module plcp_yellow_filter #(
  parameter int HOLD = 10,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_valid,
  input  logic sample_bit,
  output logic yellow
);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yellow <= 1'b0;
      run    <= '0;
    end else if (sample_valid) begin
      if (sample_bit == yellow) begin
        run <= '0;
      end else if (run == CW'(HOLD - 1)) begin
        yellow <= sample_bit;
        run    <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assert_yel_moves_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(yellow) |-> $past(sample_valid));
  assert_yel_takes_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(yellow) |-> yellow == $past(sample_bit));

endmodule

// File: rtl/plcp_frame_rx.sv
module plcp_frame_rx
  import plcp_rx_pkg::*;
#(
  parameter int          ROW_OCTETS = 57,
  parameter int          ROWS       = 12,
  parameter logic [15:0] FRAME_PAT  = 16'hF628,
  parameter int          POH_OCT    = 3,
  parameter int          YEL_ROW    = 8,
  parameter int          YEL_BIT    = 3,
  parameter int          YEL_HOLD   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic reframe_req,
  output logic oof,
  output logic frame_err,
  output logic yellow,
  output logic poh_data,
  output logic poh_en,
  output logic poh_fp
);

  localparam int OCT_W = $clog2(ROW_OCTETS);

  logic             in_frame, yel_valid, yel_bit;
  logic [OCT_W-1:0] octet_idx;
  logic [2:0]       bit_idx;
  logic [ID_W-1:0]  row_idx;

  plcp_align_fsm #(
    .ROW_OCTETS(ROW_OCTETS), .ROWS(ROWS), .FRAME_PAT(FRAME_PAT)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .reframe_req(reframe_req), .in_frame(in_frame), .frame_err(frame_err),
    .octet_idx(octet_idx), .bit_idx(bit_idx), .row_idx(row_idx)
  );

  plcp_poh_tap #(
    .OCT_W(OCT_W), .POH_OCT(POH_OCT), .YEL_ROW(YEL_ROW), .YEL_BIT(YEL_BIT)
  ) u_tap (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .in_frame(in_frame), .octet_idx(octet_idx), .bit_idx(bit_idx),
    .row_idx(row_idx), .poh_data(poh_data), .poh_en(poh_en), .poh_fp(poh_fp),
    .yel_valid(yel_valid), .yel_bit(yel_bit)
  );

  plcp_yellow_filter #(.HOLD(YEL_HOLD)) u_yel (
    .clk(clk), .rst_n(rst_n), .sample_valid(yel_valid), .sample_bit(yel_bit),
    .yellow(yellow)
  );

  assign oof = !in_frame;

  assert_no_poh_out_of_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poh_en |-> !$past(oof));

endmodule

// File: tb/tb_plcp_frame_rx.sv
`timescale 1ns/1ps
module tb_plcp_frame_rx;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, reframe_req = 1'b0;
  logic oof, frame_err, yellow, poh_data, poh_en, poh_fp;

  int checks = 0, fails = 0, fe_seen = 0, fp_seen = 0, bitcnt = 0, brow = 0, fe0, ns;
  bit gap_on = 1'b1, done = 1'b0;
  logic yel_drive = 1'b0;
  logic [1:0] exp_q[$];
  logic [1:0] item;

  always #2.5 clk = ~clk;

  plcp_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .reframe_req(reframe_req), .oof(oof), .frame_err(frame_err), .yellow(yellow),
    .poh_data(poh_data), .poh_en(poh_en), .poh_fp(poh_fp)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard for overhead bits, event counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err) fe_seen++;
      if (poh_fp) fp_seen++;
      if (poh_en) begin
        if (exp_q.size() == 0) chk("R7", "unexpected overhead bit", 1, 0);
        else begin
          item = exp_q.pop_front();
          chk("R7", "overhead bit", int'(poh_data), int'(item[1]));
          chk("R8", "frame pulse", int'(poh_fp), int'(item[0]));
        end
      end
    end
  end

  function automatic logic [7:0] idc(int k);
    logic [3:0] kk = 4'(k);
    return {kk, ~kk};
  endfunction

  function automatic logic [7:0] poh_val(int r, logic y);
    if (r == 8) return 8'h40 | (y ? 8'h08 : 8'h00);
    return 8'h40 | 8'(r);
  endfunction

  task automatic send_bit(logic b);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'b0;
    bitcnt++;
    if (gap_on && (bitcnt % 5 == 0)) @(negedge clk);
  endtask

  task automatic send_octet(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // driver: pushes the expected overhead bits, then sends the row
  task automatic send_row(logic [7:0] a1, logic [7:0] a2, logic [7:0] id, logic expect_poh);
    logic [7:0] pv = poh_val(brow, yel_drive);
    if (expect_poh)
      for (int i = 7; i >= 0; i--) exp_q.push_back({pv[i], (brow == 0) && (i == 7)});
    send_octet(a1);
    send_octet(a2);
    send_octet(id);
    send_octet(pv);
    repeat (53) send_octet(8'h00);
    brow = (brow + 1) % 12;
  endtask

  task automatic good(logic expect_poh);
    send_row(8'hF6, 8'h28, idc(11 - brow), expect_poh);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "oof after reset", int'(oof), 1);
    chk("R11", "frame_err after reset", int'(frame_err), 0);
    chk("R11", "yellow after reset", int'(yellow), 0);
    chk("R11", "poh_en after reset", int'(poh_en), 0);
    chk("R11", "poh_fp after reset", int'(poh_fp), 0);

    repeat (13) send_bit(1'b0);
    brow = 3;
    good(1'b0);
    chk("R1", "oof after first pair", int'(oof), 1);
    good(1'b1);
    chk("R1", "oof after second row", int'(oof), 0);
    chk("R5", "no error pulses during acquisition", fe_seen, 0);

    repeat (12) good(1'b1);
    chk("R8", "frame pulses in one frame", fp_seen, 1);

    fe0 = fe_seen;
    send_row(8'hF7, 8'h28, idc(11 - brow), 1'b1);
    chk("R5", "pulse on first framing octet error", fe_seen - fe0, 1);
    chk("R6", "oof after first framing octet error", int'(oof), 0);
    good(1'b1);
    fe0 = fe_seen;
    send_row(8'hF6, 8'h2A, idc(11 - brow), 1'b1);
    chk("R5", "pulse on second framing octet error", fe_seen - fe0, 1);
    chk("R6", "oof after second framing octet error", int'(oof), 0);
    good(1'b1);

    fe0 = fe_seen;
    send_row(8'hF6, 8'h28, idc(11 - brow) ^ 8'h01, 1'b1);
    chk("R5", "pulse on identifier error", fe_seen - fe0, 1);
    chk("R4", "oof after single identifier error", int'(oof), 0);
    good(1'b1);
    chk("R4", "oof after recovery row", int'(oof), 0);

    fe0 = fe_seen;
    send_row(8'hF6, 8'h28, idc(11 - brow) ^ 8'h01, 1'b1);
    send_row(8'hF6, 8'h28, idc(11 - brow) ^ 8'h01, 1'b0);
    chk("R4", "oof after two identifier errors", int'(oof), 1);
    chk("R5", "pulses for two identifier errors", fe_seen - fe0, 2);
    good(1'b0);
    chk("R1", "oof one row into reacquisition", int'(oof), 1);
    good(1'b1);
    chk("R1", "oof after reacquisition", int'(oof), 0);

    fe0 = fe_seen;
    send_row(8'hF7, 8'h29, idc(11 - brow), 1'b0);
    chk("R3", "oof after double framing error", int'(oof), 1);
    chk("R5", "pulse on double framing error", fe_seen - fe0, 1);
    good(1'b0);
    good(1'b1);
    chk("R1", "oof after relock", int'(oof), 0);

    reframe_req = 1'b1;
    @(negedge clk);
    reframe_req = 1'b0;
    chk("R10", "oof after reframe request", int'(oof), 1);
    fe0 = fe_seen;
    good(1'b0);
    send_row(8'hF6, 8'h28, idc(11 - ((brow + 1) % 12)), 1'b0);
    chk("R2", "oof after non-successor identifier", int'(oof), 1);
    good(1'b0);
    send_row(8'hF6, 8'h2A, idc(11 - brow), 1'b0);
    chk("R2", "oof after bad pair in second row", int'(oof), 1);
    chk("R5", "no pulses while out of frame", fe_seen - fe0, 0);
    good(1'b0);
    good(1'b1);
    chk("R1", "oof after lock following rejects", int'(oof), 0);

    gap_on = 1'b0;
    yel_drive = 1'b1;
    ns = 0;
    while (ns < 9) begin
      if (brow == 8) ns++;
      good(1'b1);
    end
    chk("R9", "yellow after nine set bits", int'(yellow), 0);
    while (brow != 8) good(1'b1);
    good(1'b1);
    chk("R9", "yellow after ten set bits", int'(yellow), 1);

    yel_drive = 1'b0;
    ns = 0;
    while (ns < 9) begin
      if (brow == 8) ns++;
      good(1'b1);
    end
    chk("R9", "yellow after nine clear bits", int'(yellow), 1);
    while (brow != 8) good(1'b1);
    good(1'b1);
    chk("R9", "yellow after ten clear bits", int'(yellow), 0);

    repeat (4) @(negedge clk);
    chk("R7", "expected overhead bits left over", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule